// File: doc/BRIEF.md
# Buffered Serial Character Transmitter

This block sends 8-bit characters as asynchronous serial frames. A single-entry holding register sits in front of a frame shifter. While one character is on the line, software can post the next one, and it goes out with no idle gap. The block does no baud division. An external pulse, one clock wide, marks each bit period, and every such pulse advances the line by one bit.

Three command strobes control the block. Enable lets characters in. Disable stops new characters at once but lets the character on the line, and the one waiting behind it, finish first. Reset drops everything in the same cycle. Two status outputs report the queue. The ready flag says a write will be taken, and the empty flag says nothing is held and nothing is being shifted. A parity switch and a two-bit selector choose the optional parity bit. The shifter captures both when it takes a character, so each frame keeps the settings it started with.

Top module: `serial_tx_buffered`

## Requirements
- R1: After rst_n is released, txd is 1, tx_ready is 0 and tx_empty is 1, and the block stays disabled until cmd_en is pulsed.
- R2: A cmd_en pulse while disabled makes tx_ready 1 in the following cycle. If cmd_en and cmd_dis are high in the same cycle, the disable wins and tx_ready stays 0.
- R3: A wr_stb is accepted only in a cycle where tx_ready is 1. A write at any other time changes neither the line nor the status and sends no frame.
- R4: Each frame is sent in this order:
  - a start bit of 0;
  - wr_data bit 0 through bit 7;
  - the parity bit, only when enabled;
  - a stop bit of 1.

  The line changes only on a cycle with baud_tick high, by one bit per tick. txd is 1 whenever no frame is active.
- R5: When par_on is 1 a parity bit is inserted. par_sel selects it: 0 gives even parity (the XOR of the data bits), 1 gives odd parity (the inverse of that XOR), 2 gives a constant 0 and 3 gives a constant 1. When par_on is 0 the stop bit follows data bit 7 directly. Both inputs are captured when the character enters the shifter.
- R6: A held character moves into the shifter in the cycle after its write if the shifter is idle, and txd goes to 0 in that same cycle. When a character is waiting while another is shifting, it moves in on the tick that ends the stop bit, and its start bit follows with no idle cycle.
- R7: tx_ready is 1 exactly when the block is enabled, no disable is pending and the holding register is empty. It is 0 while a second character waits behind the one being shifted.
- R8: tx_empty is 0 from the cycle after an accepted write until the final stop bit ends. It returns to 1 in the cycle after the tick that ends that stop bit.
- R9: cmd_dis drops tx_ready in the next cycle. Characters already accepted are still sent in full, after which the block is disabled. A disable while idle takes effect at once. Writes after a disable are ignored.
- R10: cmd_rst aborts any frame in progress. In the next cycle txd is 1, tx_ready is 0 and tx_empty is 1. cmd_rst overrides cmd_en and cmd_dis, and the aborted character is never resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Enable command strobe |
| cmd_dis | input | 1 | Disable (drain, then stop) command strobe |
| cmd_rst | input | 1 | Immediate transmitter reset strobe |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_stb | input | 1 | Character write strobe |
| wr_data | input | DATA_W | Character to send |
| par_on | input | 1 | Insert a parity bit |
| par_sel | input | 2 | Parity kind: 0 even, 1 odd, 2 space, 3 mark |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | A write will be accepted |
| tx_empty | output | 1 | Holding register and shifter are both empty |

## Verification
The bench decodes the serial line bit by bit and checks each frame against the characters it wrote. The directed part covers:
- a lone character, which shows the load one cycle after the write;
- two characters back to back, which shows the handoff at the stop-bit tick with no gap and the ready flag held low;
- a third write while the holding register is full, which must be dropped.

Each of the four parity kinds is run with characters whose bit count is odd and even, which separates even from odd parity and from the forced values. Disable is tried both with a queue and while idle, and reset is applied in the middle of a frame. These show draining apart from aborting. A seeded random run then mixes write gaps and parity settings.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_SPACE = 2'd2,
    PAR_MARK  = 2'd3
  } par_mode_e;

  // Picks the parity bit from the XOR of the data bits and the mode.
  function automatic logic parity_pick(input logic odd_ones, input par_mode_e mode);
    case (mode)
      PAR_EVEN:  return odd_ones;
      PAR_ODD:   return ~odd_ones;
      PAR_SPACE: return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/stx_ctrl.sv
module stx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic cmd_rst,
  input  logic wr_acc,
  input  logic hold_full,
  input  logic busy,
  output logic enabled,
  output logic dis_pend
);

  logic dis_req;
  logic drain_done;

  assign dis_req    = cmd_dis | dis_pend;
  assign drain_done = ~hold_full & ~busy & ~wr_acc;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_rst) begin
      enabled  <= 1'b0;
      dis_pend <= 1'b0;
    end else if (enabled) begin
      if (dis_req && drain_done) begin
        enabled  <= 1'b0;
        dis_pend <= 1'b0;
      end else if (cmd_dis) begin
        dis_pend <= 1'b1;
      end else if (cmd_en) begin
        dis_pend <= 1'b0;
      end
    end else if (cmd_en && !cmd_dis) begin
      enabled <= 1'b1;
    end
  end

  // R9: the block only turns off once nothing is held or shifting
  a_r9_off_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(enabled) && !$past(cmd_rst)) |-> $past(!hold_full && !busy));

  // R2: disable wins over a simultaneous enable
  a_r2_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_dis && !enabled && !cmd_rst) |=> !enabled);

endmodule

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_acc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (clr) begin
      hold_full <= 1'b0;
    end else if (wr_acc) begin
      hold_full <= 1'b1;
      hold_q    <= wr_data;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  // R3: a waiting character is never overwritten
  a_r3_held_char_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !clr) |=> $stable(hold_q));

endmodule

// File: rtl/stx_shift.sv
module stx_shift
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              par_on,
  input  par_mode_e         par_mode,
  output logic              busy,
  output logic              frame_end,
  output logic              txd
);

  localparam int FRAME_MAX = DATA_W + 3;
  localparam int IDX_W     = $clog2(FRAME_MAX);
  localparam logic [IDX_W-1:0] IDX_LASTD = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_PAR   = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] IDX_STOP  = IDX_W'(DATA_W + 2);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              pen_q;
  logic              at_last;

  assign at_last   = pen_q ? (idx == IDX_STOP) : (idx == IDX_PAR);
  assign frame_end = busy & baud_tick & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      pen_q <= 1'b0;
    end else if (clr) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      idx   <= '0;
      sh_q  <= load_data;
      par_q <= parity_pick(^load_data, par_mode);
      pen_q <= par_on;
    end else if (busy && baud_tick) begin
      if (at_last) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
        if (idx != '0 && idx <= IDX_LASTD) sh_q <= sh_q >> 1;
      end
    end
  end

  always_comb begin
    if (!busy)                txd = 1'b1;
    else if (idx == '0)       txd = 1'b0;
    else if (idx <= IDX_LASTD) txd = sh_q[0];
    else if (idx == IDX_PAR)  txd = pen_q ? par_q : 1'b1;
    else                      txd = 1'b1;
  end

  // R4: between ticks the line holds its bit
  a_r4_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick && !load && !clr) |=> $stable(txd));

  // R6: a load starts the frame with the start bit
  a_r6_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (busy && !txd));

endmodule

// File: rtl/serial_tx_buffered.sv
module serial_tx_buffered
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_rst,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              par_on,
  input  logic [1:0]        par_sel,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);

  logic              enabled;
  logic              dis_pend;
  logic              hold_full;
  logic [DATA_W-1:0] hold_q;
  logic              busy;
  logic              frame_end;
  logic              wr_acc;
  logic              load_evt;

  assign tx_ready = enabled & ~dis_pend & ~hold_full;
  assign wr_acc   = wr_stb & tx_ready;
  assign load_evt = hold_full & (~busy | frame_end) & ~cmd_rst;
  assign tx_empty = ~hold_full & ~busy;

  stx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_en    (cmd_en),
    .cmd_dis   (cmd_dis),
    .cmd_rst   (cmd_rst),
    .wr_acc    (wr_acc),
    .hold_full (hold_full),
    .busy      (busy),
    .enabled   (enabled),
    .dis_pend  (dis_pend)
  );

  stx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_rst),
    .wr_acc    (wr_acc),
    .wr_data   (wr_data),
    .load      (load_evt),
    .hold_full (hold_full),
    .hold_q    (hold_q)
  );

  stx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_rst),
    .baud_tick (baud_tick),
    .load      (load_evt),
    .load_data (hold_q),
    .par_on    (par_on),
    .par_mode  (par_mode_e'(par_sel)),
    .busy      (busy),
    .frame_end (frame_end),
    .txd       (txd)
  );

  // R10: a reset command leaves the block idle in the next cycle
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (txd && !tx_ready && tx_empty));

  // R8: when nothing is queued the line is high
  a_r8_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

endmodule

// File: tb/serial_tx_buffered_test.sv
`timescale 1ns/1ps
module serial_tx_buffered_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_en = 1'b0, cmd_dis = 1'b0, cmd_rst = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       par_on = 1'b0;
  logic [1:0] par_sel = 2'd0;
  logic       txd, tx_ready, tx_empty;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_d   [0:255];
  logic       exp_pon [0:255];
  logic [1:0] exp_ps  [0:255];
  int wr_cnt = 0;
  int rx_cnt = 0;

  bit   tick_run = 0;
  int   tick_cnt = 0;
  bit   mon_clear = 0;
  bit   mon_act = 0;
  int   mon_nb = 0;
  int   mon_len = 10;
  logic mon_bits [0:15];

  serial_tx_buffered uut (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_rst(cmd_rst),
    .baud_tick(baud_tick), .wr_stb(wr_stb), .wr_data(wr_data),
    .par_on(par_on), .par_sel(par_sel),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #2 clk = ~clk;

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] sel);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    case (sel)
      2'd0:    return (ones % 2) == 1;
      2'd1:    return (ones % 2) == 0;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (tick_run) begin
      if (tick_cnt == 3) begin baud_tick = 1'b1; tick_cnt = 0; end
      else begin baud_tick = 1'b0; tick_cnt++; end
    end else baud_tick = 1'b0;
  end

  // Line decoder, sampled shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rst_n || mon_clear) begin
      mon_act = 0;
    end else if (mon_act) begin
      if (baud_tick) begin
        if (mon_nb == mon_len - 1) begin
          logic [7:0] d;
          int k;
          k = rx_cnt % 256;
          for (int i = 0; i < 8; i++) d[i] = mon_bits[i+1];
          check(d == exp_d[k], "R4 data bits", d, exp_d[k]);
          if (exp_pon[k])
            check(mon_bits[9] == exp_par(exp_d[k], exp_ps[k]), "R5 parity bit",
                  mon_bits[9], exp_par(exp_d[k], exp_ps[k]));
          check(mon_bits[mon_len-1] == 1'b1, "R4 stop bit", mon_bits[mon_len-1], 1);
          rx_cnt++;
          mon_act = 0;
          if (txd == 1'b0) begin
            mon_act = 1; mon_nb = 0; mon_bits[0] = 1'b0;
            mon_len = exp_pon[rx_cnt % 256] ? 11 : 10;
            check(rx_cnt < wr_cnt, "R6 back-to-back start expected", rx_cnt, wr_cnt);
          end else if (!wr_stb) begin
            check(tx_empty == 1'b1, "R8 empty after stop", tx_empty, 1);
          end
        end else begin
          mon_nb++;
          mon_bits[mon_nb] = txd;
          check(tx_empty == 1'b0, "R8 empty low mid-frame", tx_empty, 0);
        end
      end
    end else if (txd == 1'b0) begin
      check(rx_cnt < wr_cnt, "R3 no unexpected frame", rx_cnt, wr_cnt);
      mon_act = 1; mon_nb = 0; mon_bits[0] = 1'b0;
      mon_len = exp_pon[rx_cnt % 256] ? 11 : 10;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit e, input bit d, input bit r);
    @(negedge clk);
    cmd_en = e; cmd_dis = d; cmd_rst = r;
    @(negedge clk);
    cmd_en = 0; cmd_dis = 0; cmd_rst = 0;
  endtask

  task automatic send(input logic [7:0] d, input bit exp_acc, input string req);
    @(negedge clk);
    check(tx_ready == exp_acc, req, tx_ready, exp_acc);
    wr_stb = 1'b1; wr_data = d;
    if (exp_acc) begin
      exp_d[wr_cnt % 256] = d;
      exp_pon[wr_cnt % 256] = par_on;
      exp_ps[wr_cnt % 256] = par_sel;
      wr_cnt++;
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !tx_ready; i++) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && !(rx_cnt == wr_cnt && tx_empty); i++) @(negedge clk);
    check(rx_cnt == wr_cnt, "R4 all accepted frames sent", rx_cnt, wr_cnt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    cyc(4);
    rst_n = 1'b1;
    tick_run = 1;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd after reset", txd, 1);
    check(tx_ready == 1'b0, "R1 ready after reset", tx_ready, 0);
    check(tx_empty == 1'b1, "R1 empty after reset", tx_empty, 1);

    // Writes while disabled are dropped
    send(8'h3C, 0, "R3 write while disabled");
    cyc(40);
    check(tx_empty == 1'b1 && txd == 1'b1, "R3 disabled write ignored", tx_empty, 1);
    check(rx_cnt == 0, "R1 nothing sent before enable", rx_cnt, 0);

    pulse(1, 1, 0);
    check(tx_ready == 1'b0, "R2 disable wins over enable", tx_ready, 0);
    pulse(1, 0, 0);
    check(tx_ready == 1'b1, "R2 ready after enable", tx_ready, 1);

    // Lone character and back-to-back handoff, no parity
    par_on = 0; par_sel = 0;
    send(8'hA5, 1, "R7 ready before write");
    check(tx_ready == 1'b0, "R7 ready low while held", tx_ready, 0);
    check(tx_empty == 1'b0, "R8 empty drops after write", tx_empty, 0);
    @(negedge clk);
    check(tx_ready == 1'b1, "R6 ready rises after load", tx_ready, 1);
    check(txd == 1'b0, "R6 start bit after load", txd, 0);
    send(8'h5A, 1, "R6 second write accepted");
    send(8'hC3, 0, "R7 write while full ignored");
    drain();

    // Every parity kind, odd and even bit counts
    par_on = 1;
    for (int s = 0; s < 4; s++) begin
      par_sel = s[1:0];
      wait_ready(); send(8'h07, 1, "R5 parity char odd ones");
      wait_ready(); send(8'h3C, 1, "R5 parity char even ones");
      drain();
    end

    // Disable with a queue drains first
    par_on = 0;
    wait_ready(); send(8'h11, 1, "R9 first queued");
    wait_ready(); send(8'h22, 1, "R9 second queued");
    pulse(0, 1, 0);
    check(tx_ready == 1'b0, "R9 ready drops on disable", tx_ready, 0);
    send(8'h33, 0, "R9 write after disable");
    drain();
    cyc(3);
    check(tx_ready == 1'b0, "R9 stopped after drain", tx_ready, 0);
    send(8'h44, 0, "R9 write when stopped");
    cyc(50);
    check(tx_empty == 1'b1 && txd == 1'b1, "R9 stopped line idle", txd, 1);

    // Disable while idle
    pulse(1, 0, 0);
    check(tx_ready == 1'b1, "R2 re-enable", tx_ready, 1);
    pulse(0, 1, 0);
    check(tx_ready == 1'b0, "R9 idle disable", tx_ready, 0);
    send(8'h55, 0, "R9 write after idle disable");

    // Reset in the middle of a frame
    pulse(1, 0, 0);
    send(8'h96, 1, "R10 char to abort");
    for (int i = 0; i < 500 && !(mon_act && mon_nb >= 3); i++) @(negedge clk);
    cmd_rst = 1'b1; mon_clear = 1;
    @(negedge clk);
    cmd_rst = 1'b0; mon_clear = 0;
    check(txd == 1'b1, "R10 line high after reset cmd", txd, 1);
    check(tx_ready == 1'b0, "R10 ready low after reset cmd", tx_ready, 0);
    check(tx_empty == 1'b1, "R10 empty after reset cmd", tx_empty, 1);
    rx_cnt = wr_cnt;
    cyc(60);
    check(txd == 1'b1 && rx_cnt == wr_cnt, "R10 no resume", rx_cnt, wr_cnt);
    pulse(1, 0, 1);
    check(tx_ready == 1'b0, "R10 overrides enable", tx_ready, 0);

    // Seeded random traffic
    pulse(1, 0, 0);
    for (int n = 0; n < 48; n++) begin
      if (n % 8 == 0) begin
        drain();
        par_on = $urandom() % 2;
        par_sel = 2'($urandom() % 4);
      end
      cyc($urandom() % 13);
      wait_ready();
      send(8'($urandom()), 1, "R4 random char accepted");
    end
    drain();
    check(tx_empty == 1'b1, "R8 empty at end", tx_empty, 1);
    finish_run();
  end

endmodule